// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage Pipeline

This block follows every instruction in a five-stage pipeline (fetch, decode, execute, memory, writeback) together with a small fault vector that travels with it. A stage that finds a problem sets bits in the vector of the instruction it currently holds. Faults are not acted on when they are raised. The vector is examined only when the instruction reaches writeback, so exceptions are taken in program order. An older instruction's fault therefore always wins, even when a younger instruction faulted first in wall-clock time.

When the instruction in writeback carries a fault, the block does the following in that cycle:
- It reports the faulting PC and a single cause code.
- It blocks that instruction's register write.
- It blocks any store of the instruction behind it.
- It raises a one-cycle flush that empties every stage.
- It redirects fetch to a fixed handler address.

Because every write is gated by a per-instruction live bit, no squashed instruction ever changes architectural state.

The pipeline advances one stage per clock. Per-stage cause inputs are qualified by the live bit of the instruction in that stage.

Top module: `exc_precise_pipe`

## Requirements
- R1: After reset, and for as long as no instruction has been fetched, `commit_o`, `rf_we_o`, `mem_we_o`, `exc_valid_o` and `flush_o` are all 0. Reset also discards instructions that are in flight.
- R2: A fault-free instruction fetched in cycle c appears in writeback in cycle c+4. In that cycle `commit_o`=1 and `commit_pc_o` is its PC. `rf_we_o`=1 in that cycle only if `id_rf_wr_i` was high while the instruction was in decode (cycle c+1).
- R3: Cause inputs are applied to the instruction held by their own stage: `if_cause_i` in cycle c, `id_illegal_i` in c+1, `ex_arith_i` in c+2, `mem_cause_i` in c+3. No exception is reported before that instruction reaches writeback in cycle c+4.
- R4: Cause codes are as follows:
  - `if_cause_i` bit0/1/2 give codes 1/2/3 (instruction page fault, misaligned fetch, fetch protection).
  - `id_illegal_i` gives code 4.
  - `ex_arith_i` gives code 5.
  - `mem_cause_i` bit0/1/2 give codes 6/7/8 (data page fault, misaligned data, data protection).
  - Code 0 means no exception.
  - If one instruction collects several causes, the lowest code is reported. This means fetch wins over decode, decode over execute, and execute over memory.
- R5: Exceptions are taken in program order. An older instruction's fault is reported even when a younger instruction posted a fault earlier, or in the same cycle. A younger instruction that is flushed by an older fault is never reported.
- R6: On delivery, the following hold for exactly one cycle: `exc_valid_o`=1, `exc_pc_o` is the faulting PC, `exc_cause_o` is the code, `flush_o`=1, and `redirect_valid_o`=1 with `redirect_pc_o` equal to the handler address (default 0x80).
- R7: The faulting instruction neither commits nor writes the register file. No instruction that was younger than it commits, writes, or raises an exception afterwards.
- R8: `mem_we_o` is 1 only when all of the following hold in that cycle: a live instruction is in the memory stage, `mem_store_i`=1, that instruction has no cause so far (including this cycle's `mem_cause_i`), and `flush_o`=0.
- R9: Cause inputs and `mem_store_i` for a stage that holds no live instruction are ignored.
- R10: An instruction presented to fetch in the same cycle as `flush_o` is dropped and never commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid_i | input | 1 | An instruction enters fetch this cycle |
| fetch_pc_i | input | PC_W | PC of the fetched instruction |
| if_cause_i | input | 3 | Fetch faults: page, misaligned, protection |
| id_illegal_i | input | 1 | Decode found an undefined or illegal opcode |
| id_rf_wr_i | input | 1 | Decoded instruction writes a register |
| ex_arith_i | input | 1 | Execute raised an arithmetic exception |
| mem_cause_i | input | 3 | Data faults: page, misaligned, protection |
| mem_store_i | input | 1 | Memory-stage instruction wants to store |
| commit_o | output | 1 | Writeback instruction retires cleanly |
| commit_pc_o | output | PC_W | PC of the retiring instruction |
| rf_we_o | output | 1 | Gated register-file write enable |
| mem_we_o | output | 1 | Gated data-memory write enable |
| exc_valid_o | output | 1 | Exception delivered this cycle |
| exc_cause_o | output | 4 | Cause code of the delivered exception |
| exc_pc_o | output | PC_W | PC of the faulting instruction |
| flush_o | output | 1 | Flush all stages |
| redirect_valid_o | output | 1 | Fetch must restart at redirect_pc_o |
| redirect_pc_o | output | PC_W | Handler address |

## Verification
The assertions check, on every cycle, the properties that hold locally in time:
- A delivery always comes with flush, redirect to the handler and a nonzero code.
- A flush lasts one cycle and leaves writeback empty in the following cycle.
- A faulting instruction never writes a register.
- A store never passes during a flush or without a request.
- Nothing retires in the cycle after reset.

Only the directed scenarios can show the behaviours that need knowledge of the whole instruction stream:
- the cycle in which each instruction retires;
- which of several faults wins between two instructions, or within one instruction;
- that a younger faulted instruction stays silent after an older fault;
- that causes posted to empty stages are ignored.

// File: rtl/exc_track_pkg.sv
package exc_track_pkg;

    // Number of pipeline registers after fetch: ID, EX, MEM, WB
    localparam int NUM_SLOTS = 4;
    localparam int NUM_CAUSE = 8;
    localparam int CODE_W    = 4;

    // Cause vector bit positions; order sets reporting priority
    localparam int CB_IF_PAGE   = 0;
    localparam int CB_IF_ALIGN  = 1;
    localparam int CB_IF_PROT   = 2;
    localparam int CB_ID_ILL    = 3;
    localparam int CB_EX_ARITH  = 4;
    localparam int CB_MEM_PAGE  = 5;
    localparam int CB_MEM_ALIGN = 6;
    localparam int CB_MEM_PROT  = 7;

    localparam int SLOT_ID  = 0;
    localparam int SLOT_EX  = 1;
    localparam int SLOT_MEM = 2;
    localparam int SLOT_WB  = 3;

    typedef logic [NUM_CAUSE-1:0] cause_vec_t;

    typedef enum logic [CODE_W-1:0] {
        EXC_NONE       = 4'd0,
        EXC_FETCH_PAGE = 4'd1,
        EXC_FETCH_ALGN = 4'd2,
        EXC_FETCH_PROT = 4'd3,
        EXC_ILLEGAL    = 4'd4,
        EXC_ARITH      = 4'd5,
        EXC_DATA_PAGE  = 4'd6,
        EXC_DATA_ALGN  = 4'd7,
        EXC_DATA_PROT  = 4'd8
    } exc_code_e;

    typedef struct packed {
        logic       live;
        logic       rf_wr;
        cause_vec_t vec;
    } slot_t;

    localparam slot_t SLOT_EMPTY = '{live: 1'b0, rf_wr: 1'b0, vec: '0};

    // Lowest set bit wins: earliest stage has priority
    function automatic exc_code_e first_cause(cause_vec_t v);
        exc_code_e c;
        c = EXC_NONE;
        for (int i = NUM_CAUSE - 1; i >= 0; i--) begin
            if (v[i]) c = exc_code_e'(CODE_W'(i + 1));
        end
        return c;
    endfunction

endpackage

// File: rtl/exc_slot_reg.sv
module exc_slot_reg
    import exc_track_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  slot_t           d_slot,
    input  logic [PC_W-1:0] d_pc,
    output slot_t           q_slot,
    output logic [PC_W-1:0] q_pc
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            q_slot <= SLOT_EMPTY;
        end else begin
            q_slot <= d_slot;
        end
    end

    // PC needs no reset: it is only meaningful while live
    always_ff @(posedge clk) begin
        q_pc <= d_pc;
    end

endmodule

// File: rtl/exc_cause_merge.sv
module exc_cause_merge
    import exc_track_pkg::*;
(
    input  slot_t      in_slot,
    input  cause_vec_t post_vec,
    input  logic       post_rf_wr,
    output slot_t      out_slot
);

    always_comb begin
        out_slot = in_slot;
        if (in_slot.live) begin
            out_slot.vec   = in_slot.vec | post_vec;
            out_slot.rf_wr = in_slot.rf_wr | post_rf_wr;
        end
    end

endmodule

// File: rtl/exc_retire_unit.sv
module exc_retire_unit
    import exc_track_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
    input  slot_t             wb_slot,
    input  logic [PC_W-1:0]   wb_pc,
    output logic              commit,
    output logic [PC_W-1:0]   commit_pc,
    output logic              rf_we,
    output logic              exc_valid,
    output logic [CODE_W-1:0] exc_cause,
    output logic [PC_W-1:0]   exc_pc,
    output logic              flush,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   redirect_pc
);

    logic faulted;

    always_comb begin
        faulted        = wb_slot.live && (wb_slot.vec != '0);
        commit         = wb_slot.live && !faulted;
        commit_pc      = wb_pc;
        rf_we          = commit && wb_slot.rf_wr;
        exc_valid      = faulted;
        exc_cause      = faulted ? first_cause(wb_slot.vec) : EXC_NONE;
        exc_pc         = wb_pc;
        flush          = faulted;
        redirect_valid = faulted;
        redirect_pc    = HANDLER_PC;
    end

endmodule

// File: rtl/exc_store_gate.sv
module exc_store_gate
    import exc_track_pkg::*;
(
    input  slot_t mem_slot,
    input  logic  store_req,
    input  logic  flush,
    output logic  mem_we
);

    // mem_slot already carries this cycle's memory-stage causes
    always_comb begin
        mem_we = mem_slot.live && store_req && (mem_slot.vec == '0) && !flush;
    end

endmodule

// File: rtl/exc_precise_pipe.sv
module exc_precise_pipe
    import exc_track_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid_i,
    input  logic [PC_W-1:0]   fetch_pc_i,
    input  logic [2:0]        if_cause_i,
    input  logic              id_illegal_i,
    input  logic              id_rf_wr_i,
    input  logic              ex_arith_i,
    input  logic [2:0]        mem_cause_i,
    input  logic              mem_store_i,
    output logic              commit_o,
    output logic [PC_W-1:0]   commit_pc_o,
    output logic              rf_we_o,
    output logic              mem_we_o,
    output logic              exc_valid_o,
    output logic [CODE_W-1:0] exc_cause_o,
    output logic [PC_W-1:0]   exc_pc_o,
    output logic              flush_o,
    output logic              redirect_valid_o,
    output logic [PC_W-1:0]   redirect_pc_o
);

    localparam int NUM_POST = NUM_SLOTS - 1;

    // d side: index k feeds register k; q side: register k holds stage k
    slot_t           slot_d [NUM_SLOTS];
    slot_t           slot_q [NUM_SLOTS];
    logic [PC_W-1:0] pc_d   [NUM_SLOTS];
    logic [PC_W-1:0] pc_q   [NUM_SLOTS];

    cause_vec_t      post_vec [NUM_POST];
    logic            post_rf  [NUM_POST];

    logic            flush_w;

    // Fetch stage: the new instruction starts with its fetch causes
    always_comb begin
        slot_d[SLOT_ID]       = SLOT_EMPTY;
        slot_d[SLOT_ID].live  = fetch_valid_i;
        slot_d[SLOT_ID].vec[CB_IF_PROT:CB_IF_PAGE] =
            fetch_valid_i ? if_cause_i : 3'b000;
        pc_d[SLOT_ID]         = fetch_pc_i;
    end

    // Per-stage postings into the vector of the held instruction
    always_comb begin
        for (int k = 0; k < NUM_POST; k++) begin
            post_vec[k] = '0;
            post_rf[k]  = 1'b0;
        end
        post_vec[SLOT_ID][CB_ID_ILL]                   = id_illegal_i;
        post_rf[SLOT_ID]                               = id_rf_wr_i;
        post_vec[SLOT_EX][CB_EX_ARITH]                 = ex_arith_i;
        post_vec[SLOT_MEM][CB_MEM_PROT:CB_MEM_PAGE]    = mem_cause_i;
    end

    for (genvar k = 0; k < NUM_POST; k++) begin : g_merge
        exc_cause_merge i_merge (
            .in_slot    (slot_q[k]),
            .post_vec   (post_vec[k]),
            .post_rf_wr (post_rf[k]),
            .out_slot   (slot_d[k+1])
        );
        assign pc_d[k+1] = pc_q[k];
    end

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        exc_slot_reg #(.PC_W(PC_W)) i_reg (
            .clk    (clk),
            .rst    (rst),
            .flush  (flush_w),
            .d_slot (slot_d[k]),
            .d_pc   (pc_d[k]),
            .q_slot (slot_q[k]),
            .q_pc   (pc_q[k])
        );
    end

    exc_retire_unit #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) i_retire (
        .wb_slot        (slot_q[SLOT_WB]),
        .wb_pc          (pc_q[SLOT_WB]),
        .commit         (commit_o),
        .commit_pc      (commit_pc_o),
        .rf_we          (rf_we_o),
        .exc_valid      (exc_valid_o),
        .exc_cause      (exc_cause_o),
        .exc_pc         (exc_pc_o),
        .flush          (flush_w),
        .redirect_valid (redirect_valid_o),
        .redirect_pc    (redirect_pc_o)
    );

    // slot_d[SLOT_WB] is the memory-stage instruction with this cycle's causes
    exc_store_gate i_store (
        .mem_slot  (slot_d[SLOT_WB]),
        .store_req (mem_store_i),
        .flush     (flush_w),
        .mem_we    (mem_we_o)
    );

    assign flush_o = flush_w;

endmodule

// File: rtl/exc_precise_chk.sv
module exc_precise_chk
    import exc_track_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0080
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_store_i,
    input logic              commit_o,
    input logic              rf_we_o,
    input logic              mem_we_o,
    input logic              exc_valid_o,
    input logic [CODE_W-1:0] exc_cause_o,
    input logic              flush_o,
    input logic              redirect_valid_o,
    input logic [PC_W-1:0]   redirect_pc_o
);

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!commit_o && !exc_valid_o && !rf_we_o));

    assert_rf_we_needs_commit_R2: assert property (@(posedge clk) disable iff (rst)
        rf_we_o |-> (commit_o && !exc_valid_o));

    assert_delivery_bundle_R6: assert property (@(posedge clk) disable iff (rst)
        exc_valid_o |-> (flush_o && redirect_valid_o &&
                         redirect_pc_o == HANDLER_PC && exc_cause_o != '0));

    assert_flush_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> !flush_o);

    assert_no_write_on_fault_R7: assert property (@(posedge clk) disable iff (rst)
        exc_valid_o |-> (!rf_we_o && !commit_o));

    assert_younger_silent_R7: assert property (@(posedge clk) disable iff (rst)
        flush_o |=> (!commit_o && !exc_valid_o && !rf_we_o));

    assert_store_gated_R8: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |-> (mem_store_i && !flush_o));

endmodule

bind exc_precise_pipe exc_precise_chk #(.PC_W(PC_W), .HANDLER_PC(HANDLER_PC)) i_chk (
    .clk              (clk),
    .rst              (rst),
    .mem_store_i      (mem_store_i),
    .commit_o         (commit_o),
    .rf_we_o          (rf_we_o),
    .mem_we_o         (mem_we_o),
    .exc_valid_o      (exc_valid_o),
    .exc_cause_o      (exc_cause_o),
    .flush_o          (flush_o),
    .redirect_valid_o (redirect_valid_o),
    .redirect_pc_o    (redirect_pc_o)
);

// File: tb/test_exc_precise_pipe.sv
module test_exc_precise_pipe;

    localparam int          PC_W    = 32;
    localparam logic [31:0] HANDLER = 32'h0000_0080;

    logic              clk = 1'b0;
    logic              rst;
    logic              fetch_valid_i;
    logic [PC_W-1:0]   fetch_pc_i;
    logic [2:0]        if_cause_i;
    logic              id_illegal_i;
    logic              id_rf_wr_i;
    logic              ex_arith_i;
    logic [2:0]        mem_cause_i;
    logic              mem_store_i;
    logic              commit_o;
    logic [PC_W-1:0]   commit_pc_o;
    logic              rf_we_o;
    logic              mem_we_o;
    logic              exc_valid_o;
    logic [3:0]        exc_cause_o;
    logic [PC_W-1:0]   exc_pc_o;
    logic              flush_o;
    logic              redirect_valid_o;
    logic [PC_W-1:0]   redirect_pc_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    exc_precise_pipe #(.PC_W(PC_W), .HANDLER_PC(HANDLER)) i_exc_precise_pipe (
        .clk(clk), .rst(rst),
        .fetch_valid_i(fetch_valid_i), .fetch_pc_i(fetch_pc_i),
        .if_cause_i(if_cause_i), .id_illegal_i(id_illegal_i),
        .id_rf_wr_i(id_rf_wr_i), .ex_arith_i(ex_arith_i),
        .mem_cause_i(mem_cause_i), .mem_store_i(mem_store_i),
        .commit_o(commit_o), .commit_pc_o(commit_pc_o),
        .rf_we_o(rf_we_o), .mem_we_o(mem_we_o),
        .exc_valid_o(exc_valid_o), .exc_cause_o(exc_cause_o),
        .exc_pc_o(exc_pc_o), .flush_o(flush_o),
        .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs;
        fetch_valid_i = 1'b0; fetch_pc_i = '0; if_cause_i = 3'b000;
        id_illegal_i = 1'b0; id_rf_wr_i = 1'b0; ex_arith_i = 1'b0;
        mem_cause_i = 3'b000; mem_store_i = 1'b0;
    endtask

    // Advance one clock; inputs are then set and outputs sampled mid-cycle
    task automatic tick;
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic settle;
        #1;
    endtask

    task automatic drain;
        for (int i = 0; i < 6; i++) tick();
    endtask

    task automatic fetch(input logic [31:0] pc, input logic [2:0] fc);
        fetch_valid_i = 1'b1; fetch_pc_i = pc; if_cause_i = fc;
    endtask

    // Watch for n cycles that nothing commits, writes or excepts
    task automatic expect_silent(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            settle();
            chk(req, "commit silent", {31'b0, commit_o}, 32'd0);
            chk(req, "exc silent", {31'b0, exc_valid_o}, 32'd0);
            chk(req, "rf_we silent", {31'b0, rf_we_o}, 32'd0);
            tick();
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; idle_inputs();
        tick(); tick();
        rst = 1'b0;
        idle_inputs(); mem_store_i = 1'b1; settle();
        chk("R1", "commit after reset", {31'b0, commit_o}, 32'd0);
        chk("R1", "exc after reset", {31'b0, exc_valid_o}, 32'd0);
        chk("R1", "flush after reset", {31'b0, flush_o}, 32'd0);
        chk("R1", "mem_we after reset", {31'b0, mem_we_o}, 32'd0);
        tick();
        // in-flight instruction discarded by reset
        fetch(32'h0000_0900, 3'b000); tick(); tick();
        rst = 1'b1; tick(); rst = 1'b0;
        expect_silent("R1", 5);
    endtask

    task automatic t_clean;
        fetch(32'h0000_0100, 3'b000); settle(); tick();           // c0
        id_rf_wr_i = 1'b1; settle();                              // c1
        chk("R2", "no early commit", {31'b0, commit_o}, 32'd0);
        tick(); tick(); settle();                                 // c3
        chk("R2", "not yet committed", {31'b0, commit_o}, 32'd0);
        tick(); settle();                                         // c4
        chk("R2", "commit", {31'b0, commit_o}, 32'd1);
        chk("R2", "commit pc", commit_pc_o, 32'h0000_0100);
        chk("R2", "rf_we", {31'b0, rf_we_o}, 32'd1);
        chk("R2", "no exc", {31'b0, exc_valid_o}, 32'd0);
        drain();
        // non-writer commits without rf_we
        fetch(32'h0000_0104, 3'b000); tick(); tick(); tick(); tick(); settle();
        chk("R2", "commit nonwriter", {31'b0, commit_o}, 32'd1);
        chk("R2", "rf_we nonwriter", {31'b0, rf_we_o}, 32'd0);
        drain();
    endtask

    task automatic t_multi_cause;
        fetch(32'h0000_0200, 3'b110); tick();                     // c0: misaligned+prot
        settle(); chk("R3", "no exc in ID", {31'b0, exc_valid_o}, 32'd0); tick();
        ex_arith_i = 1'b1; settle();                              // c2
        chk("R3", "no exc in EX", {31'b0, exc_valid_o}, 32'd0); tick();
        mem_cause_i = 3'b001; settle();                           // c3
        chk("R3", "no exc in MEM", {31'b0, exc_valid_o}, 32'd0); tick();
        fetch(32'h0000_02F0, 3'b000); settle();                   // c4: dropped fetch
        chk("R6", "exc_valid", {31'b0, exc_valid_o}, 32'd1);
        chk("R4", "cause fetch misaligned", {28'b0, exc_cause_o}, 32'd2);
        chk("R6", "exc pc", exc_pc_o, 32'h0000_0200);
        chk("R6", "flush", {31'b0, flush_o}, 32'd1);
        chk("R6", "redirect valid", {31'b0, redirect_valid_o}, 32'd1);
        chk("R6", "redirect pc", redirect_pc_o, HANDLER);
        chk("R7", "no commit on fault", {31'b0, commit_o}, 32'd0);
        tick(); settle();
        chk("R6", "flush one cycle", {31'b0, flush_o}, 32'd0);
        expect_silent("R10", 5);
    endtask

    task automatic t_priority(input string req, input logic [31:0] pc,
                              input logic ill, input logic ar, input logic [2:0] mc,
                              input logic [31:0] exp_code);
        fetch(pc, 3'b000); tick();
        id_illegal_i = ill; tick();
        ex_arith_i = ar; tick();
        mem_cause_i = mc; tick();
        settle();
        chk(req, "exc_valid", {31'b0, exc_valid_o}, 32'd1);
        chk(req, "cause code", {28'b0, exc_cause_o}, exp_code);
        chk(req, "exc pc", exc_pc_o, pc);
        drain();
    endtask

    task automatic t_order;
        fetch(32'h0000_0400, 3'b000); tick();                     // c0 A
        fetch(32'h0000_0404, 3'b001); tick();                     // c1 B faults first
        fetch(32'h0000_0408, 3'b000); tick();                     // c2 C
        fetch(32'h0000_040C, 3'b100); mem_cause_i = 3'b001;       // c3 D + A load fault
        settle();
        chk("R5", "no exc before A in WB", {31'b0, exc_valid_o}, 32'd0);
        tick(); settle();                                         // c4
        chk("R5", "older wins valid", {31'b0, exc_valid_o}, 32'd1);
        chk("R5", "older wins pc", exc_pc_o, 32'h0000_0400);
        chk("R5", "older wins cause", {28'b0, exc_cause_o}, 32'd6);
        tick();
        expect_silent("R5", 5);
    endtask

    task automatic t_kill_store;
        fetch(32'h0000_0500, 3'b001); tick();                     // c0 A faults
        fetch(32'h0000_0504, 3'b000); tick();                     // c1 B
        id_rf_wr_i = 1'b1; tick();                                // c2 B in ID
        tick();                                                   // c3
        mem_store_i = 1'b1; settle();                             // c4 B in MEM
        chk("R7", "A excepts", {31'b0, exc_valid_o}, 32'd1);
        chk("R8", "store killed by flush", {31'b0, mem_we_o}, 32'd0);
        tick();
        expect_silent("R7", 4);
    endtask

    task automatic t_store_gate;
        fetch(32'h0000_0600, 3'b000); tick(); tick(); tick();
        mem_store_i = 1'b1; settle();
        chk("R8", "clean store", {31'b0, mem_we_o}, 32'd1);
        drain();
        fetch(32'h0000_0610, 3'b000); tick(); tick(); tick();
        mem_store_i = 1'b1; mem_cause_i = 3'b100; settle();
        chk("R8", "own mem fault blocks store", {31'b0, mem_we_o}, 32'd0);
        drain();
        fetch(32'h0000_0620, 3'b000); tick(); tick();
        ex_arith_i = 1'b1; tick();
        mem_store_i = 1'b1; settle();
        chk("R8", "earlier fault blocks store", {31'b0, mem_we_o}, 32'd0);
        drain();
    endtask

    task automatic t_ignore_empty;
        fetch(32'h0000_0700, 3'b000); tick();                     // c0
        ex_arith_i = 1'b1; mem_cause_i = 3'b111; mem_store_i = 1'b1; settle();
        chk("R9", "store to empty MEM", {31'b0, mem_we_o}, 32'd0);
        tick();                                                   // c1 done
        mem_cause_i = 3'b010; tick();                             // c2: EX holds instr, MEM empty
        tick(); settle();                                         // c4
        chk("R9", "empty-stage causes ignored", {31'b0, commit_o}, 32'd1);
        chk("R9", "no exc", {31'b0, exc_valid_o}, 32'd0);
        chk("R9", "commit pc", commit_pc_o, 32'h0000_0700);
        drain();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_multi_cause();
        t_priority("R4", 32'h0000_0300, 1'b1, 1'b0, 3'b001, 32'd4);
        t_priority("R4", 32'h0000_0310, 1'b0, 1'b1, 3'b100, 32'd5);
        t_priority("R4", 32'h0000_0320, 1'b0, 1'b0, 3'b110, 32'd7);
        t_priority("R4", 32'h0000_0330, 1'b0, 1'b0, 3'b100, 32'd8);
        t_order();
        t_kill_store();
        t_store_gate();
        t_ignore_empty();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule